// File: doc/BRIEF.md
# Sequential Nonrestoring Unsigned Divider

This block divides an unsigned N-bit dividend by an unsigned N-bit divisor over several clock cycles. It uses a single adder/subtractor. An (N+1)-bit partial remainder register carries a sign bit. A shift register holds the dividend at the start and the quotient at the end. In every step the block shifts the partial remainder and the quotient register left together. It then adds or subtracts the divisor, chosen by the sign the remainder had before the step, so it never has to undo a subtraction. After N steps, one correction cycle adds the divisor back if the remainder is negative.

The client pulses `start` with the operands present. `busy` stays high while the operation runs. A one-cycle `done` pulse marks valid results, and the results then stay on the outputs until the next accepted start. A zero divisor needs no special path: it produces an all-ones quotient and returns the dividend as the remainder.

Top module: `seq_divider`

## Requirements
- R1: When `done` is high, `quotient` equals floor(dividend / divisor) for a non-zero divisor, with both operands treated as unsigned.
- R2: When `done` is high, `remainder` equals dividend mod divisor for a non-zero divisor, and is therefore below the divisor.
- R3: When `start` is sampled high at a clock edge while `busy` is low, `done` rises after exactly N+1 further rising edges.
- R4: `done` is high for exactly one cycle per accepted operation.
- R5: `busy` is high for the N+1 cycles after an accepted start and low in the cycle where `done` is high.
- R6: `start` is ignored while `busy` is high. It does not change the running operation's result or latency, and it produces no extra `done`.
- R7: With a zero divisor, `quotient` is all ones and `remainder` equals the dividend.
- R8: After `done`, `quotient` and `remainder` hold their values until the next accepted start.
- R9: While reset (`rstN` low, asynchronous) is asserted, `busy` and `done` are low and `quotient` and `remainder` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division when idle |
| dividend | input | N | Unsigned dividend, sampled with start |
| divisor | input | N | Unsigned divisor, sampled with start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| quotient | output | N | Unsigned quotient |
| remainder | output | N | Unsigned remainder |

## Verification
The bench compares results against a restoring-division model. It goes after cases where a nonrestoring design most often fails. If the final correction is missing, the remainder comes out negative, and the remainder for exact divisions and for divisors above the dividend is wrong. If the sign is taken from the wrong bit, the quotient goes wrong at full-scale operands such as 255/1 and 255/255. A divisor of zero must yield an all-ones quotient with the dividend as remainder. A stray start pulse raised mid-operation must neither reload the operands nor restart the count, which would change the result or delay `done`. The bench also counts cycles from start to `done`, and that count exposes an off-by-one iteration counter.

// File: rtl/divider_pkg.sv
package divider_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } divState_t;

  typedef struct packed {
    logic load;
    logic step;
    logic fix;
  } dpCtrl_t;
endpackage

// File: rtl/divider_datapath.sv
module divider_datapath
  import divider_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCtrl_t      ctrl,
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  output logic [N-1:0] quotient,
  output logic [N-1:0] remainder
);
  localparam int AW = N + 1;

  logic [AW-1:0] aReg;
  logic [N-1:0]  qReg;
  logic [N-1:0]  mReg;
  logic [AW-1:0] mExt;
  logic [AW-1:0] shifted;
  logic [AW-1:0] stepSum;
  logic [AW-1:0] fixSum;

  assign mExt    = {1'b0, mReg};
  assign shifted = {aReg[N-1:0], qReg[N-1]};
  assign stepSum = aReg[AW-1] ? (shifted + mExt) : (shifted - mExt);
  assign fixSum  = aReg[AW-1] ? (aReg + mExt) : aReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg <= '0;
      qReg <= '0;
      mReg <= '0;
    end else if (ctrl.load) begin
      aReg <= '0;
      qReg <= dividend;
      mReg <= divisor;
    end else if (ctrl.step) begin
      aReg <= stepSum;
      qReg <= {qReg[N-2:0], ~stepSum[AW-1]};
    end else if (ctrl.fix) begin
      aReg <= fixSum;
    end
  end

  assign quotient  = qReg;
  assign remainder = aReg[N-1:0];

  // R2: after the correction cycle the partial remainder is non-negative and below a non-zero divisor
  p_rem_nonneg_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.fix) |-> (!aReg[AW-1] && (mReg == '0 || aReg[N-1:0] < mReg)));

  // R8: with no control strobe, the result registers keep their contents
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.load && !ctrl.step && !ctrl.fix) |=> ($stable(qReg) && $stable(aReg)));
endmodule

// File: rtl/divider_control.sv
module divider_control
  import divider_pkg::*;
#(
  parameter int N = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output dpCtrl_t ctrl,
  output logic    busy,
  output logic    done
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  divState_t state;
  logic [CW-1:0] iterCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            iterCnt <= '0;
          end
        end
        ST_RUN: begin
          if (iterCnt == LAST) state <= ST_FIX;
          iterCnt <= iterCnt + 1'b1;
        end
        ST_FIX: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.load = (state == ST_IDLE) && start;
    ctrl.step = (state == ST_RUN);
    ctrl.fix  = (state == ST_FIX);
  end

  assign busy = (state != ST_IDLE);

  // R4: done never lasts two cycles
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5: done and busy never overlap
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R6: no operand load while an operation runs
  p_no_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctrl.load);

  // R3: busy only rises after a start
  p_busy_from_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R3: the iteration counter never passes the operand width
  p_iter_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (iterCnt < CW'(N)));
endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import divider_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] quotient,
  output logic [N-1:0] remainder
);
  dpCtrl_t ctrl;

  divider_control #(.N(N)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctrl  (ctrl),
    .busy  (busy),
    .done  (done)
  );

  divider_datapath #(.N(N)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder)
  );
endmodule

// File: tb/sim_seq_divider.sv
module sim_seq_divider;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] dividend = '0;
  logic [N-1:0] divisor = '0;
  logic busy, done;
  logic [N-1:0] quotient, remainder;

  int checks = 0;
  int fails = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  seq_divider #(.N(N)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder)
  );

  localparam logic [15:0] VEC [12] = '{
    {8'd100, 8'd7}, {8'd255, 8'd1}, {8'd255, 8'd255}, {8'd0, 8'd5},
    {8'd5, 8'd200}, {8'd128, 8'd16}, {8'd200, 8'd3}, {8'd17, 8'd17},
    {8'd254, 8'd255}, {8'd143, 8'd11}, {8'd1, 8'd2}, {8'd255, 8'd128}
  };

  function automatic logic [2*N-1:0] refDiv(input logic [N-1:0] dd, input logic [N-1:0] dv);
    logic [N:0] a;
    logic [N-1:0] q;
    a = '0;
    q = dd;
    for (int i = 0; i < N; i++) begin
      a = {a[N-1:0], q[N-1]};
      q = q << 1;
      if (a >= {1'b0, dv}) begin
        a = a - {1'b0, dv};
        q[0] = 1'b1;
      end
    end
    return {q, a[N-1:0]};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Runs one division; intrude>0 raises start again at that busy cycle
  task automatic runDiv(input logic [N-1:0] dd, input logic [N-1:0] dv, input int intrude);
    logic [2*N-1:0] exp;
    int cyc;
    exp = refDiv(dd, dv);
    @(negedge clk);
    dividend = dd;
    divisor  = dv;
    start    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < N + 5) begin
      if (cyc > 0) check("R5 busy during run", int'(busy), 1);
      if (intrude > 0 && cyc == intrude) begin
        dividend = ~dd;
        divisor  = dv + 8'd1;
        start    = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      #1;
      cyc++;
    end
    start = 1'b0;
    check("R3 latency", cyc, N + 1);
    check("R4 done seen", int'(done), 1);
    check("R5 busy low at done", int'(busy), 0);
    check("R1 quotient", int'(quotient), int'(exp[2*N-1:N]));
    check("R2 remainder", int'(remainder), int'(exp[N-1:0]));
    @(posedge clk);
    #1;
    check("R4 done one cycle", int'(done), 0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9: reset values
    repeat (3) @(posedge clk);
    #1;
    check("R9 busy", int'(busy), 0);
    check("R9 done", int'(done), 0);
    check("R9 quotient", int'(quotient), 0);
    check("R9 remainder", int'(remainder), 0);
    @(negedge clk);
    rstN = 1'b1;

    foreach (VEC[i]) runDiv(VEC[i][15:8], VEC[i][7:0], 0);

    for (int a = 3; a < 256; a += 41)
      for (int b = 1; b < 256; b += 29)
        runDiv(8'(a), 8'(b), 0);

    // R7: zero divisor
    runDiv(8'd77, 8'd0, 0);
    check("R7 quotient all ones", int'(quotient), 255);
    check("R7 remainder = dividend", int'(remainder), 77);
    runDiv(8'd0, 8'd0, 0);
    check("R7 zero/zero quotient", int'(quotient), 255);

    // R6: start while busy has no effect
    runDiv(8'd201, 8'd9, 3);
    check("R6 quotient unaffected", int'(quotient), 22);
    check("R6 remainder unaffected", int'(remainder), 3);
    repeat (N + 3) begin
      @(posedge clk);
      #1;
      check("R6 no extra done", int'(done), 0);
      check("R6 stays idle", int'(busy), 0);
    end

    // R8: results hold after done
    runDiv(8'd250, 8'd6, 0);
    dividend = 8'd9;
    divisor  = 8'd2;
    repeat (6) @(posedge clk);
    #1;
    check("R8 quotient held", int'(quotient), 41);
    check("R8 remainder held", int'(remainder), 4);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule